// File: doc/BRIEF.md
# Long Binary Divider with Test Mode

This block is a 24-stage binary divider built as a synchronous counter that advances on the falling edge of its input clock. Only the seven most significant stages are brought out, as a tap bus giving the input frequency divided by 2^18 up to 2^24. The count can therefore run through 16,777,216 input edges before it wraps. An oscillator-enable output is held low for as long as reset is active, so that an external clock source can be stopped while the divider is idle.

The stages are grouped into three 8-stage sections. In serial mode the sections chain, so that each one steps only when every section below it is full. A test select breaks that chain. Every section then steps on every input edge. After 255 edges in that mode each stage holds a one, and a single serial edge afterwards sends the whole counter back to zero. This lets a tester exercise every stage in a few hundred edges rather than millions.

Top module: `long_tap_divider`

## Requirements
- R1: While `rst_async` is high, all stages are cleared without waiting for a clock edge: `tap` reads 0 and `osc_en` reads 0. Both stay at 0 across falling edges for as long as reset is held.
- R2: After `rst_async` falls, `osc_en` goes high on the second falling edge of `clk_in`. Those two edges do not advance the count, and counting starts on the third falling edge.
- R3: With `test_sel` low, the 24-stage count goes up by one on every falling edge of `clk_in`, and rising edges have no effect. `tap[k]` is count bit 17+k, so `tap[0]` (the divide-by-2^18 stage) first reads 1 after exactly 2^17 falling edges from zero, and not after 2^17-1.
- R4: With `test_sel` high, each 8-bit section (bits 0-7, 8-15 and 16-23) goes up by one on every falling edge. `tap` then reads bits 1 to 7 of the top section, which after k edges from zero is (k>>1) for k below 256.
- R5: Starting from zero, 255 falling edges with `test_sel` high set all 24 stages to one, and `tap` reads 7'h7F.
- R6: With `test_sel` low and all stages at one, a single falling edge sets all stages to zero, and `tap` reads 0.
- R7: Changing `test_sel` between falling edges leaves the stored count unchanged, so `tap` keeps its value.
- R8: With `test_sel` high, a section that holds 255 wraps to 0 on the next edge without stepping the section above it. After 256 edges from zero, `tap` reads 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock. The count advances on its falling edge |
| rst_async | input | 1 | Active-high reset. Asserts asynchronously and is released on a falling edge |
| test_sel | input | 1 | 1 = three sections count in parallel, 0 = one serial chain |
| osc_en | output | 1 | Oscillator enable. Low during reset and until the release completes |
| tap | output | 7 | Outputs of stages 18 to 24 (bit 0 = divide by 2^18) |

## Verification
The count register updates on a falling edge, and `tap` follows it through logic only. The bench therefore waits for the required number of falling edges and samples one nanosecond after the next rising edge, half a period away from the active edge. Inputs are driven at that same point. The reset checks sample one nanosecond after `rst_async` rises and no clock edge in between, because clearing must not wait for a clock. `osc_en` is checked after the first and after the second falling edge following release, and the counting checks add two edges of latency for the release before the first counted edge. The 2^17 boundary is checked on both sides, at 2^17-1 and at 2^17 edges.

// File: rtl/ltd_pkg.sv
package ltd_pkg;

   // Chain configuration selected by test_sel
   typedef enum logic {
      CHAIN_SERIAL   = 1'b0,
      CHAIN_PARALLEL = 1'b1
   } chain_mode_e;

   // Number of tap bits for a chain of total stages with lowest visible stage lo (1-based)
   function automatic int tap_width(input int total, input int lo);
      return total - lo + 1;
   endfunction

endpackage

// File: rtl/ltd_rst_sync.sv
// Reset release synchronizer on the falling edge of the input clock.
module ltd_rst_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_in,
   input  logic rst_async,
   output logic rst_n
);

   logic [SYNC_STAGES-1:0] shreg;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("ltd_rst_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(negedge clk_in or posedge rst_async) begin
      if (rst_async) begin
         shreg <= '0;
      end else begin
         shreg <= {shreg[SYNC_STAGES-2:0], 1'b1};
      end
   end

   assign rst_n = shreg[SYNC_STAGES-1];

endmodule

// File: rtl/ltd_section.sv
// One section of the divider chain: a W-bit counter with a step enable.
module ltd_section #(
   parameter int W = 8
) (
   input  logic         clk_in,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] cnt,
   output logic         full
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 1) begin : g_bad_width
         $error("ltd_section: W must be positive");
      end
   endgenerate

   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt + ONE;
      end
   end

   assign full = &cnt;

endmodule

// File: rtl/ltd_carry_ctrl.sv
// Step enables for each section: chained carries in serial mode, all high in parallel mode.
module ltd_carry_ctrl
   import ltd_pkg::*;
#(
   parameter int SEG_N = 3
) (
   input  chain_mode_e      mode,
   input  logic [SEG_N-1:0] full,
   output logic [SEG_N-1:0] step
);

   generate
      if (SEG_N < 1) begin : g_bad_count
         $error("ltd_carry_ctrl: SEG_N must be positive");
      end
   endgenerate

   assign step[0] = 1'b1;

   generate
      for (genvar i = 1; i < SEG_N; i++) begin : g_chain
         assign step[i] = (mode == CHAIN_PARALLEL) ? 1'b1 : (step[i-1] & full[i-1]);
      end
   endgenerate

   // full of the top section is not needed for any enable
   logic unused_top_full;
   assign unused_top_full = full[SEG_N-1];

endmodule

// File: rtl/ltd_tap_pick.sv
// Brings out stages TAP_LO..TOTAL (1-based) of the flattened count.
module ltd_tap_pick #(
   parameter int TOTAL  = 24,
   parameter int TAP_LO = 18,
   parameter int TAP_W  = TOTAL - TAP_LO + 1
) (
   input  logic [TOTAL-1:0] cnt,
   output logic [TAP_W-1:0] tap
);

   generate
      if (TAP_LO < 1 || TAP_LO > TOTAL) begin : g_bad_tap
         $error("ltd_tap_pick: TAP_LO out of range");
      end
      if (TAP_W != TOTAL - TAP_LO + 1) begin : g_bad_tap_w
         $error("ltd_tap_pick: TAP_W inconsistent with TOTAL and TAP_LO");
      end
   endgenerate

   generate
      for (genvar k = 0; k < TAP_W; k++) begin : g_tap
         assign tap[k] = cnt[TAP_LO - 1 + k];
      end
      if (TAP_LO > 1) begin : g_hidden
         logic [TAP_LO-2:0] unused_low;
         assign unused_low = cnt[TAP_LO-2:0];
      end
   endgenerate

endmodule

// File: rtl/long_tap_divider.sv
// Long binary divider: SEG_N sections of SEG_W stages, top stages tapped.
module long_tap_divider
   import ltd_pkg::*;
#(
   parameter int SEG_W       = 8,
   parameter int SEG_N       = 3,
   parameter int TAP_LO      = 18,
   parameter int SYNC_STAGES = 2,
   localparam int TOTAL      = SEG_W * SEG_N,
   localparam int TAP_W      = TOTAL - TAP_LO + 1
) (
   input  logic             clk_in,
   input  logic             rst_async,
   input  logic             test_sel,
   output logic             osc_en,
   output logic [TAP_W-1:0] tap
);

   generate
      if (SEG_W < 1 || SEG_N < 1) begin : g_bad_geom
         $error("long_tap_divider: SEG_W and SEG_N must be positive");
      end
      if (TAP_LO < 1 || TAP_LO > TOTAL) begin : g_bad_tap
         $error("long_tap_divider: TAP_LO must lie within the chain");
      end
      if (TAP_W != tap_width(TOTAL, TAP_LO)) begin : g_bad_tapw
         $error("long_tap_divider: tap width mismatch");
      end
   endgenerate

   logic             rst_n;
   chain_mode_e      mode;
   logic [SEG_N-1:0] full;
   logic [SEG_N-1:0] step;
   logic [TOTAL-1:0] cnt_all;

   assign mode = test_sel ? CHAIN_PARALLEL : CHAIN_SERIAL;

   ltd_rst_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_rst (
      .clk_in   (clk_in),
      .rst_async(rst_async),
      .rst_n    (rst_n)
   );

   ltd_carry_ctrl #(
      .SEG_N(SEG_N)
   ) u_carry (
      .mode(mode),
      .full(full),
      .step(step)
   );

   generate
      for (genvar i = 0; i < SEG_N; i++) begin : g_sec
         ltd_section #(
            .W(SEG_W)
         ) u_sec (
            .clk_in(clk_in),
            .rst_n (rst_n),
            .step  (step[i]),
            .cnt   (cnt_all[i*SEG_W +: SEG_W]),
            .full  (full[i])
         );
      end
   endgenerate

   ltd_tap_pick #(
      .TOTAL (TOTAL),
      .TAP_LO(TAP_LO),
      .TAP_W (TAP_W)
   ) u_tap (
      .cnt(cnt_all),
      .tap(tap)
   );

   assign osc_en = rst_n;

endmodule

// File: rtl/ltd_checker.sv
// Properties for long_tap_divider, bound to every instance.
module ltd_checker #(
   parameter int SEG_W = 8,
   parameter int SEG_N = 3,
   parameter int TAP_W = 7,
   localparam int TOTAL = SEG_W * SEG_N
) (
   input logic             clk_in,
   input logic             rst_async,
   input logic             test_sel,
   input logic             osc_en,
   input logic [TAP_W-1:0] tap,
   input logic [TOTAL-1:0] cnt_all
);

   // R1: reset clears the outputs regardless of clock
   assert_reset_clear_R1: assert property (@(posedge clk_in)
      rst_async |-> (tap == '0 && !osc_en));

   // R2: enable rises only after a falling edge with reset low
   assert_release_R2: assert property (@(negedge clk_in) disable iff (rst_async)
      $rose(osc_en) |-> !$past(rst_async));

   // R2: count is held at zero until release has completed
   assert_hold_zero_R2: assert property (@(negedge clk_in) disable iff (rst_async)
      !osc_en |=> (cnt_all == '0));

   // R3: serial mode steps the full count by one
   assert_serial_step_R3: assert property (@(negedge clk_in) disable iff (rst_async)
      (osc_en && !test_sel) |=> (cnt_all == TOTAL'($past(cnt_all) + 1'b1)));

   // R4, R8: parallel mode steps every section by one, wrapping within the section
   generate
      for (genvar i = 0; i < SEG_N; i++) begin : g_sec_chk
         assert_parallel_step_R4: assert property (@(negedge clk_in) disable iff (rst_async)
            (osc_en && test_sel) |=>
               (cnt_all[i*SEG_W +: SEG_W] == SEG_W'($past(cnt_all[i*SEG_W +: SEG_W]) + 1'b1)));
      end
   endgenerate

endmodule

bind long_tap_divider ltd_checker #(
   .SEG_W(SEG_W),
   .SEG_N(SEG_N),
   .TAP_W(TAP_W)
) u_chk (
   .clk_in   (clk_in),
   .rst_async(rst_async),
   .test_sel (test_sel),
   .osc_en   (osc_en),
   .tap      (tap),
   .cnt_all  (cnt_all)
);

// File: tb/sim_long_tap_divider.sv
`timescale 1ns/1ps
module sim_long_tap_divider;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tsel = 1'b0;
   logic       osc;
   logic [6:0] tap;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   long_tap_divider u0 (
      .clk_in   (clk),
      .rst_async(rst),
      .test_sel (tsel),
      .osc_en   (osc),
      .tap      (tap)
   );

   task automatic check_tap(input string req, input logic [6:0] exp);
      n_chk++;
      if (tap !== exp) begin
         n_fail++;
         $display("FAIL %s tap actual=%h expected=%h at %0t", req, tap, exp, $time);
      end
   endtask

   task automatic check_osc(input string req, input logic exp);
      n_chk++;
      if (osc !== exp) begin
         n_fail++;
         $display("FAIL %s osc_en actual=%b expected=%b at %0t", req, osc, exp, $time);
      end
   endtask

   // wait n falling edges, then sample just after the following rising edge
   task automatic run_edges(input int n);
      repeat (n) @(negedge clk);
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset_state;
      run_edges(0);
      check_tap("R1", 7'h00);
      check_osc("R1", 1'b0);
   endtask

   task automatic t_release;
      rst = 1'b0;
      #1;
      check_osc("R2", 1'b0);
      run_edges(1);
      check_osc("R2", 1'b0);
      check_tap("R2", 7'h00);
      run_edges(1);
      check_osc("R2", 1'b1);
      check_tap("R2", 7'h00);
   endtask

   task automatic t_reset_mid;
      rst = 1'b1;
      #1;
      check_tap("R1", 7'h00);
      check_osc("R1", 1'b0);
      run_edges(2);
      check_tap("R1", 7'h00);
      rst = 1'b0;
      run_edges(2);
      check_osc("R2", 1'b1);
   endtask

   task automatic t_parallel_fill;
      tsel = 1'b1;
      run_edges(100);
      check_tap("R4", 7'd50);
      run_edges(155);
      check_tap("R5", 7'h7F);
   endtask

   task automatic t_mode_keep(input logic [6:0] exp, input logic new_sel);
      tsel = new_sel;
      #2;
      check_tap("R7", exp);
   endtask

   task automatic t_rollover;
      run_edges(1);
      check_tap("R6", 7'h00);
      check_osc("R6", 1'b1);
   endtask

   task automatic t_parallel_wrap;
      tsel = 1'b1;
      run_edges(200);
      check_tap("R4", 7'd100);
      run_edges(56);
      check_tap("R8", 7'h00);
      run_edges(2);
      check_tap("R8", 7'h01);
   endtask

   task automatic t_serial_q18;
      run_edges(131071);
      check_tap("R3", 7'h00);
      run_edges(1);
      check_tap("R3", 7'h01);
   endtask

   task automatic t_switch_mid;
      // count is 0x020000: top section holds 2
      t_mode_keep(7'h01, 1'b1);
      run_edges(1);
      check_tap("R4", 7'h01);
      run_edges(1);
      check_tap("R4", 7'h02);
      t_mode_keep(7'h02, 1'b0);
   endtask

   initial begin
      #1800000;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset_state();
      t_release();
      t_parallel_fill();
      t_mode_keep(7'h7F, 1'b0);
      t_rollover();
      t_parallel_wrap();
      tsel = 1'b0;
      t_reset_mid();
      t_serial_q18();
      t_switch_mid();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule